// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an 8-bit parallel flash bus. It accepts one request at a time: program a byte, erase the sector that holds an address, or erase the whole chip. For each request it writes the unlock and command cycles with active-low chip enable, output enable and write enable. It then reads the status byte in pairs until the embedded operation settles. The result comes back as a one-cycle done strobe with a fail flag. Every bus cycle has four parts: setup, strobe, hold and recovery. The length of each part is a parameter counted in clock cycles.

Completion is judged by the toggle bit, which is bit 6 of the status byte. The limit bit, bit 5, forces one extra pair of reads before a still-toggling operation is given up. A host-side read budget bounds the polling. Any failure is followed by a reset command write before the block reports.

The sequencer steps through these states:
- S_IDLE goes to S_CMD when a request arrives.
- S_CMD moves through the command steps, then goes to S_RD_A.
- S_RD_A goes to S_RD_B, which goes to S_JUDGE.
- S_JUDGE goes to S_DONE when bit 6 is steady. It goes to S_RE_A when the bit toggles and bit 5 is set. It goes to S_ABORT when the read budget is spent. Otherwise it goes back to S_RD_A.
- S_RE_A goes to S_RE_B, which goes to S_REJUDGE.
- S_REJUDGE goes to S_DONE when bit 6 is steady and to S_ABORT when it still toggles.
- S_ABORT goes to S_DONE, and S_DONE goes to S_IDLE.

Top module: `flsh_seq_ctrl`

## Requirements
- R1: With req_op = 0 (byte program), the block writes four cycles in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then req_data at req_addr.
- R2: With req_op = 1 (sector erase), the block writes six cycles in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@req_addr.
- R3: With req_op = 2 or 3 (chip erase), the block writes the same first five cycles as R2 and then 10h at 555h.
- R4: In every bus cycle, chip enable is low and the address and data are held for T_AS clocks before the strobe. The strobe (WE for a write, OE for a read) is low for exactly T_WP clocks. Chip enable, address and data stay held for T_AH clocks after the strobe.
- R5: WE and OE are never low together. fl_dq_oe is high only during write cycles.
- R6: After the command, status reads at req_addr come in pairs. When bit 6 is equal in both reads of a pair, the block reports pass and issues no further bus cycle.
- R7: If bit 6 differs within a pair and bit 5 is 1 in either read, the block makes exactly one more pair of reads. It passes if bit 6 is equal in that pair and fails otherwise.
- R8: If bit 6 differs, bit 5 is 0, and the total number of status reads has reached MAX_POLL, the block fails.
- R9: Every failed request ends with one write of F0h at address 0 before done. A passing request writes nothing after its command.
- R10: req_ready is high only when the block is idle. done is a single-cycle pulse with done_fail valid alongside it, and req_ready is high in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Idle, ready for a request |
| done | output | 1 | One-cycle completion strobe |
| done_fail | output | 1 | Outcome flag, valid with done |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Write data toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Read data from the flash |

## Verification
The embedded assertions check bus safety on every cycle. WE and OE never overlap, data is driven only on writes, a strobe never appears without chip enable, and the address stays still while WE is low. The assertions also check the done-pulse shape. The command order, the number of status reads, and the choice between pass, recheck, watchdog failure and reset-command cleanup only show up in scenarios. To cover them, the bench's flash model sweeps the busy length and the bit 5 behaviour, and it predicts each read count and outcome arithmetically.

// File: rtl/flsh_pkg.sv
package flsh_pkg;

    localparam int DQ_W    = 8;
    localparam int TOG_BIT = 6;
    localparam int LIM_BIT = 5;

    localparam logic [1:0] OP_PROG   = 2'd0;
    localparam logic [1:0] OP_SERASE = 2'd1;

    localparam logic [7:0] CMD_RESET = 8'hF0;

    typedef struct packed {
        logic        use_req;
        logic [11:0] addr;
        logic [7:0]  data;
    } cmd_step_t;

    function automatic logic [2:0] cmd_len(input logic [1:0] op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic cmd_step_t cmd_step(input logic [1:0] op,
                                           input logic [2:0] idx,
                                           input logic [7:0] pdata);
        cmd_step_t s;
        s = '{use_req: 1'b0, addr: 12'h555, data: 8'hAA};
        unique case (idx)
            3'd0: s = '{use_req: 1'b0, addr: 12'h555, data: 8'hAA};
            3'd1: s = '{use_req: 1'b0, addr: 12'h2AA, data: 8'h55};
            3'd2: s = '{use_req: 1'b0, addr: 12'h555,
                        data: (op == OP_PROG) ? 8'hA0 : 8'h80};
            3'd3: s = (op == OP_PROG) ? '{use_req: 1'b1, addr: 12'h000, data: pdata}
                                      : '{use_req: 1'b0, addr: 12'h555, data: 8'hAA};
            3'd4: s = '{use_req: 1'b0, addr: 12'h2AA, data: 8'h55};
            3'd5: s = (op == OP_SERASE) ? '{use_req: 1'b1, addr: 12'h000, data: 8'h30}
                                        : '{use_req: 1'b0, addr: 12'h555, data: 8'h10};
            default: s = '{use_req: 1'b0, addr: 12'h000, data: CMD_RESET};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flsh_poll_eval.sv
module flsh_poll_eval
    import flsh_pkg::*;
(
    input  logic [DQ_W-1:0] first_rd,
    input  logic [DQ_W-1:0] second_rd,
    output logic            toggled,
    output logic            limit_hit
);
    always_comb begin
        toggled   = first_rd[TOG_BIT] ^ second_rd[TOG_BIT];
        limit_hit = first_rd[LIM_BIT] | second_rd[LIM_BIT];
    end
endmodule

// File: rtl/flsh_bus_phy.sv
module flsh_bus_phy
    import flsh_pkg::*;
#(
    parameter int AW    = 17,
    parameter int T_AS  = 1,
    parameter int T_WP  = 2,
    parameter int T_AH  = 1,
    parameter int T_WPH = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_write,
    input  logic [AW-1:0]   addr_in,
    input  logic [DQ_W-1:0] wdata_in,
    output logic            cyc_done,
    output logic [DQ_W-1:0] rdata,
    output logic            ce_n,
    output logic            oe_n,
    output logic            we_n,
    output logic [AW-1:0]   addr,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe,
    input  logic [DQ_W-1:0] dq_in
);
    localparam int TMAX_A = (T_AS > T_WP) ? T_AS : T_WP;
    localparam int TMAX_B = (T_AH > T_WPH) ? T_AH : T_WPH;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CW     = $clog2(TMAX + 1);

    typedef enum logic [2:0] {P_IDLE, P_SETUP, P_STROBE, P_HOLD, P_GAP} phase_e;

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= P_IDLE;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            dq_oe    <= 1'b0;
            addr     <= '0;
            dq_out   <= '0;
            rdata    <= '0;
            cyc_done <= 1'b0;
        end else begin
            cyc_done <= 1'b0;
            unique case (ph_q)
                P_IDLE: if (start) begin
                    addr   <= addr_in;
                    dq_out <= wdata_in;
                    wr_q   <= is_write;
                    ce_n   <= 1'b0;
                    dq_oe  <= is_write;
                    cnt_q  <= CW'(T_AS - 1);
                    ph_q   <= P_SETUP;
                end
                P_SETUP: if (cnt_q == '0) begin
                    we_n  <= ~wr_q;
                    oe_n  <= wr_q;
                    cnt_q <= CW'(T_WP - 1);
                    ph_q  <= P_STROBE;
                end else cnt_q <= cnt_q - 1'b1;
                P_STROBE: if (cnt_q == '0) begin
                    we_n  <= 1'b1;
                    oe_n  <= 1'b1;
                    if (!wr_q) rdata <= dq_in;
                    cnt_q <= CW'(T_AH - 1);
                    ph_q  <= P_HOLD;
                end else cnt_q <= cnt_q - 1'b1;
                P_HOLD: if (cnt_q == '0) begin
                    ce_n  <= 1'b1;
                    dq_oe <= 1'b0;
                    cnt_q <= CW'(T_WPH - 1);
                    ph_q  <= P_GAP;
                end else cnt_q <= cnt_q - 1'b1;
                P_GAP: if (cnt_q == '0) begin
                    cyc_done <= 1'b1;
                    ph_q     <= P_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: ph_q <= P_IDLE;
            endcase
        end
    end

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    p_drive_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !ce_n);
    p_addr_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out)));
endmodule

// File: rtl/flsh_seq_ctrl.sv
module flsh_seq_ctrl
    import flsh_pkg::*;
#(
    parameter int AW       = 17,
    parameter int T_AS     = 1,
    parameter int T_WP     = 2,
    parameter int T_AH     = 1,
    parameter int T_WPH    = 1,
    parameter int MAX_POLL = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DQ_W-1:0] req_data,
    output logic            req_ready,
    output logic            done,
    output logic            done_fail,
    output logic            fl_ce_n,
    output logic            fl_oe_n,
    output logic            fl_we_n,
    output logic [AW-1:0]   fl_addr,
    output logic [DQ_W-1:0] fl_dq_out,
    output logic            fl_dq_oe,
    input  logic [DQ_W-1:0] fl_dq_in
);
    localparam int NW = $clog2(MAX_POLL + 2) + 1;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_RD_A, S_RD_B, S_JUDGE,
        S_RE_A, S_RE_B, S_REJUDGE, S_ABORT, S_DONE
    } st_e;

    st_e             st_q, st_d;
    logic [1:0]      op_q;
    logic [AW-1:0]   addr_q;
    logic [DQ_W-1:0] data_q, rd_a_q, rd_b_q;
    logic [2:0]      step_q;
    logic [NW-1:0]   nreads_q;
    logic            pend_q, fail_q;

    logic            ph_start, ph_write, ph_done;
    logic [AW-1:0]   ph_addr;
    logic [DQ_W-1:0] ph_wdata, ph_rdata;
    logic            toggled, limit_hit;
    cmd_step_t       cur_step;
    logic            bus_state;

    assign cur_step = cmd_step(op_q, step_q, data_q);

    flsh_poll_eval u_eval (
        .first_rd (rd_a_q),
        .second_rd(rd_b_q),
        .toggled  (toggled),
        .limit_hit(limit_hit)
    );

    flsh_bus_phy #(.AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_AH(T_AH), .T_WPH(T_WPH)) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ph_start),
        .is_write(ph_write),
        .addr_in (ph_addr),
        .wdata_in(ph_wdata),
        .cyc_done(ph_done),
        .rdata   (ph_rdata),
        .ce_n    (fl_ce_n),
        .oe_n    (fl_oe_n),
        .we_n    (fl_we_n),
        .addr    (fl_addr),
        .dq_out  (fl_dq_out),
        .dq_oe   (fl_dq_oe),
        .dq_in   (fl_dq_in)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:    if (req_valid) st_d = S_CMD;
            S_CMD:     if (ph_done && step_q == cmd_len(op_q) - 3'd1) st_d = S_RD_A;
            S_RD_A:    if (ph_done) st_d = S_RD_B;
            S_RD_B:    if (ph_done) st_d = S_JUDGE;
            S_JUDGE: begin
                if (!toggled)                       st_d = S_DONE;
                else if (limit_hit)                 st_d = S_RE_A;
                else if (nreads_q >= NW'(MAX_POLL)) st_d = S_ABORT;
                else                                st_d = S_RD_A;
            end
            S_RE_A:    if (ph_done) st_d = S_RE_B;
            S_RE_B:    if (ph_done) st_d = S_REJUDGE;
            S_REJUDGE: st_d = toggled ? S_ABORT : S_DONE;
            S_ABORT:   if (ph_done) st_d = S_DONE;
            S_DONE:    st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            op_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            rd_a_q   <= '0;
            rd_b_q   <= '0;
            step_q   <= '0;
            nreads_q <= '0;
            pend_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ph_start) pend_q <= 1'b1;
            if (ph_done)  pend_q <= 1'b0;
            unique case (st_q)
                S_IDLE: if (req_valid) begin
                    op_q     <= req_op;
                    addr_q   <= req_addr;
                    data_q   <= req_data;
                    step_q   <= '0;
                    nreads_q <= '0;
                    fail_q   <= 1'b0;
                end
                S_CMD: if (ph_done) step_q <= step_q + 3'd1;
                S_RD_A, S_RE_A: if (ph_done) begin
                    rd_a_q   <= ph_rdata;
                    nreads_q <= nreads_q + 1'b1;
                end
                S_RD_B, S_RE_B: if (ph_done) begin
                    rd_b_q   <= ph_rdata;
                    nreads_q <= nreads_q + 1'b1;
                end
                S_JUDGE:   if (toggled && !limit_hit && nreads_q >= NW'(MAX_POLL)) fail_q <= 1'b1;
                S_REJUDGE: if (toggled) fail_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_state = (st_q == S_CMD) || (st_q == S_RD_A) || (st_q == S_RD_B) ||
                    (st_q == S_RE_A) || (st_q == S_RE_B) || (st_q == S_ABORT);
        ph_start  = bus_state && !pend_q;
        ph_write  = (st_q == S_CMD) || (st_q == S_ABORT);
        ph_addr   = addr_q;
        ph_wdata  = cur_step.data;
        if (st_q == S_CMD && !cur_step.use_req) ph_addr = AW'(cur_step.addr);
        if (st_q == S_ABORT) begin
            ph_addr  = '0;
            ph_wdata = CMD_RESET;
        end
        req_ready = (st_q == S_IDLE);
        done      = (st_q == S_DONE);
        done_fail = fail_q;
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ready_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    p_abort_marks_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ABORT) |-> fail_q);
    p_no_bus_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_we_n && fl_oe_n));
endmodule

// File: tb/flsh_seq_ctrl_tb.sv
module flsh_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 17;
    localparam int T_AS  = 2;
    localparam int T_WP  = 3;
    localparam int T_AH  = 1;
    localparam int T_WPH = 2;
    localparam int MAXP  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_ready, done, done_fail;
    logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    flsh_seq_ctrl #(.AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_AH(T_AH), .T_WPH(T_WPH),
                    .MAX_POLL(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .done_fail(done_fail), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    // flash model
    int            busy_left = 0;
    bit            busy_inf = 0;
    bit            tq = 0;
    bit            q5_mode = 0;
    int            sc_busy = 0;
    bit            sc_stuck = 0;
    int            sc_len = 4;
    int            nw = 0;
    int            nr = 0;
    logic [AW-1:0] wl_addr [0:15];
    logic [7:0]    wl_data [0:15];
    logic          we_prev = 1'b1, oe_prev = 1'b1;
    int            lowcnt = 0;
    int            oelow = 0;
    int            bus_err = 0;

    assign fl_dq_in = {1'b0, tq, q5_mode, 5'b00000};

    always @(negedge clk) begin
        if (!fl_we_n && !fl_oe_n) bus_err++;
        if (!fl_we_n) begin
            lowcnt++;
            if (fl_ce_n || !fl_dq_oe) bus_err++;
        end
        if (!fl_oe_n) begin
            oelow++;
            if (fl_ce_n || fl_dq_oe) bus_err++;
        end
        if (!we_prev && fl_we_n) begin
            if (lowcnt != T_WP) bus_err++;
            lowcnt = 0;
            if (nw < 16) begin
                wl_addr[nw] = fl_addr;
                wl_data[nw] = fl_dq_out;
            end
            nw++;
            if (fl_dq_out == 8'hF0) begin
                busy_left = 0;
                busy_inf  = 0;
            end else if (nw == sc_len) begin
                busy_left = sc_busy;
                busy_inf  = sc_stuck;
            end
        end
        if (!oe_prev && fl_oe_n) begin
            if (oelow != T_WP) bus_err++;
            oelow = 0;
            if (fl_addr != req_addr) bus_err++;
            nr++;
            if (busy_inf || busy_left > 0) begin
                tq = ~tq;
                if (!busy_inf) busy_left--;
            end
        end
        we_prev = fl_we_n;
        oe_prev = fl_oe_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void exp_write(input int op, input int idx, input logic [AW-1:0] a,
                                      input logic [7:0] d, output logic [AW-1:0] ea,
                                      output logic [7:0] ed);
        ea = AW'(12'h555);
        ed = 8'hAA;
        if (idx == 1 || idx == 4) begin ea = AW'(12'h2AA); ed = 8'h55; end
        if (idx == 2) ed = (op == 0) ? 8'hA0 : 8'h80;
        if (idx == 3 && op == 0) begin ea = a; ed = d; end
        if (idx == 5) begin
            if (op == 1) begin ea = a; ed = 8'h30; end
            else ed = 8'h10;
        end
    endfunction

    task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int b, input bit stuck, input bit q5);
        int  exp_reads, k, waitc;
        bit  exp_fail, got_fail, seen;
        int  mism;
        logic [AW-1:0] ea;
        logic [7:0]    ed;
        string rq;
        // expected outcome computed from the requirements
        if (stuck) begin
            exp_fail = 1; exp_reads = q5 ? 4 : MAXP;
        end else if (q5) begin
            exp_reads = (b == 0) ? 2 : 4;
            exp_fail  = (b >= 3);
        end else begin
            k = (b + 1) / 2;
            if (2 * k >= MAXP) begin exp_fail = 1; exp_reads = MAXP; end
            else begin exp_fail = 0; exp_reads = 2 * k + 2; end
        end
        rq = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";

        @(negedge clk);
        sc_len = (op == 0) ? 4 : 6;
        sc_busy = b; sc_stuck = stuck; q5_mode = q5;
        nw = 0; nr = 0; bus_err = 0;
        req_op = 2'(op); req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; got_fail = 0; waitc = 0;
        while (!seen && waitc < 3000) begin
            @(negedge clk);
            waitc++;
            if (done) begin seen = 1; got_fail = done_fail; end
        end
        check(seen, "R10", "done seen", int'(seen), 1);
        mism = 0;
        for (int i = 0; i < sc_len && i < nw; i++) begin
            exp_write(op, i, a, d, ea, ed);
            if (wl_addr[i] !== ea || wl_data[i] !== ed) mism++;
        end
        check(mism == 0, rq, "command cycle mismatches", mism, 0);
        check(nw == sc_len + (exp_fail ? 1 : 0), "R9", "write count", nw,
              sc_len + (exp_fail ? 1 : 0));
        if (exp_fail && nw == sc_len + 1)
            check(wl_data[sc_len] == 8'hF0 && wl_addr[sc_len] == '0, "R9",
                  "reset write data", int'(wl_data[sc_len]), 8'hF0);
        check(nr == exp_reads, q5 ? "R7" : (exp_fail ? "R8" : "R6"), "status reads",
              nr, exp_reads);
        check(got_fail == exp_fail, q5 ? "R7" : (exp_fail ? "R8" : "R6"), "fail flag",
              int'(got_fail), int'(exp_fail));
        check(bus_err == 0, "R4", "strobe width/setup/overlap R5 errors", bus_err, 0);
        @(negedge clk);
        check(req_ready && !done, "R10", "idle after done", int'(req_ready), 1);
        check(nw == sc_len + (exp_fail ? 1 : 0) && nr == exp_reads, "R6",
              "no bus cycles after done", nr, exp_reads);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !done && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe,
              "R10", "reset state", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && fl_we_n && fl_oe_n, "R5", "idle bus after reset",
              int'(fl_we_n), 1);
        for (int op = 0; op < 3; op++)
            for (int b = 0; b <= 10; b++)
                run_op(op, AW'(17'h1C000 + op * 17'h0123 + b), 8'(8'h3C ^ b), b, 0, 0);
        for (int b = 0; b <= 4; b++)
            run_op(0, AW'(17'h00777 + b), 8'h5A, b, 0, 1);
        for (int op = 0; op < 4; op++) begin
            run_op(op, AW'(17'h08000), 8'h11, 0, 1, 1);
            run_op(op, AW'(17'h0A5A5), 8'h22, 0, 1, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule